// File: doc/BRIEF.md
# Memory-Mapped Serial Console

A byte-oriented serial console that sits on a simple 64-bit register bus. Software pushes characters into a transmit queue through one register and pulls received characters from a receive queue through another. A third register reports four queue flags, a fourth sets the baud divisor and a fifth selects which queue conditions raise the interrupt line. A transmit engine drains its queue onto the serial output. A receive engine samples the serial input and loads complete characters into its queue.

Every bit period spans sixteen oversample ticks. A tick occurs every (divisor + 1) system clocks, so software programs the divisor as the system clock over sixteen times the baud rate, minus one. For example, 50 MHz and 115200 baud give 26. Software polls the transmit-full flag before each write and the receive-empty flag before each read. Both queues are 16 characters deep.

Top module: `con_uart`

## Requirements
- R1: After reset, the status word reads 0x3 (both queues empty, neither full), the divisor and interrupt-enable registers read 0, the serial output is high and the interrupt output is low.
- R2: Registers are 64-bit words at byte offsets 0x00 (transmit, write-only), 0x08 (receive), 0x10 (status), 0x18 (divisor) and 0x20 (interrupt enable). In the status word, bit 0 means the receive queue is empty, bit 1 means the transmit queue is empty, bit 2 means the receive queue is full and bit 3 means the transmit queue is full. All other bits read 0.
- R3: Each character leaves in the same order it was written, taken from data bits 7:0. The frame is one low start bit, eight data bits starting with bit 0, and one high stop bit. The line stays high between frames.
- R4: The divisor register reads back what was written. A data bit on the serial output lasts exactly 16 × (divisor + 1) clocks.
- R5: A read of the receive register returns the oldest received character in bits 7:0, with bits 63:8 zero, and removes it from the queue.
- R6: A received frame whose stop bit samples low is discarded.
- R7: A write to the transmit register while the transmit queue is full is ignored. The transmitter takes one character out as soon as it goes idle. So with the line idle and the divisor at 0, 17 back-to-back writes fill the queue, and later writes are lost. A read of the receive register while its queue is empty returns 0 and changes nothing.
- R8: The receive queue holds 16 characters and sets its full flag when it does. A character that completes while the queue is full is dropped.
- R9: Interrupt-enable bit 0 raises the interrupt output while the receive queue holds data. Bit 1 raises it while the transmit queue is empty. The output is the OR of the enabled conditions.
- R10: A low pulse on the serial input that has ended before the eighth oversample tick after the falling edge is not taken as a start bit.
- R11: A receive-register read that lands in the same cycle as an incoming character being stored returns the older character, and both characters are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access; bits 2:0 must be zero for a hit |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; pops the receive queue at offset 0x08 |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for the addressed register, combinational |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of actions can hit one queue in the same cycle. One pair is a software read and the receive engine storing a character. The other is a software write and the transmit engine taking a character. The first pair is provoked by a sweep. Each trial leaves one character in the receive queue, starts a second frame, and issues one read at an offset that moves a cycle per trial across the stop bit. Every trial must return the older character, then the newer one, then report empty. The second pair occurs naturally in a burst of back-to-back writes. There the transmitter's first pull coincides with the second write, and the scoreboard must then see exactly seventeen frames in order.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;

   // word index (byte offset / 8) of each register
   localparam int unsigned IDX_TXD  = 0;
   localparam int unsigned IDX_RXD  = 1;
   localparam int unsigned IDX_STAT = 2;
   localparam int unsigned IDX_DIV  = 3;
   localparam int unsigned IDX_IEN  = 4;

   localparam int unsigned CHAR_W = 8;
   localparam int unsigned OSR    = 16;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/con_fifo.sv
module con_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]     cnt;
   logic              push_ok, pop_ok;

   if (DEPTH < 2) begin : g_bad_depth
      $error("con_fifo: DEPTH must be at least 2");
   end

   // pointer advance: free wrap for powers of two, explicit wrap otherwise
   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nx;
         if (pop_ok)  rp <= rp_nx;
         if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
         else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
      end
   end

   // a push into a full queue leaves the fill level alone
   assert_full_push_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> ($stable(cnt) && full));

   // a pop from an empty queue leaves it empty
   assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

   // simultaneous push and pop on a partly filled queue keeps the level
   assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty && !full) |=> $stable(cnt));

endmodule

// File: rtl/con_tx.sv
module con_tx
   import con_uart_pkg::*;
#(
   parameter int unsigned DATA_W = CHAR_W,
   parameter int unsigned SAMP   = OSR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   output logic              txd
);
   localparam int unsigned FRAME = DATA_W + 2;
   localparam int unsigned BW    = $clog2(FRAME);
   localparam int unsigned TW    = $clog2(SAMP);

   logic             busy;
   logic [FRAME-1:0] sh;
   logic [BW-1:0]    nbit;
   logic [TW-1:0]    tcnt;
   logic             txd_q;

   if (SAMP < 2) begin : g_bad_samp
      $error("con_tx: SAMP must be at least 2");
   end

   assign q_pop = !busy && !q_empty;
   assign txd   = txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sh    <= '1;
         nbit  <= '0;
         tcnt  <= '0;
         txd_q <= 1'b1;
      end else if (!busy) begin
         txd_q <= 1'b1;
         if (!q_empty) begin
            busy  <= 1'b1;
            sh    <= {1'b1, q_data, 1'b0};
            nbit  <= '0;
            tcnt  <= '0;
            txd_q <= 1'b0;
         end
      end else if (tick) begin
         tcnt <= (tcnt == TW'(SAMP - 1)) ? '0 : tcnt + 1'b1;
         if (tcnt == TW'(SAMP - 1)) begin
            if (nbit == BW'(FRAME - 1)) begin
               busy  <= 1'b0;
               txd_q <= 1'b1;
            end else begin
               nbit  <= nbit + 1'b1;
               sh    <= {1'b1, sh[FRAME-1:1]};
               txd_q <= sh[1];
            end
         end
      end
   end

   assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd_q));

endmodule

// File: rtl/con_rx.sv
module con_rx
   import con_uart_pkg::*;
#(
   parameter int unsigned DATA_W = CHAR_W,
   parameter int unsigned SAMP   = OSR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic              push,
   output logic [DATA_W-1:0] data
);
   localparam int unsigned TW   = $clog2(SAMP);
   localparam int unsigned NBW  = $clog2(DATA_W);
   localparam int unsigned HALF = SAMP / 2;

   logic [2:0]        sync;
   logic              rx_s, rx_prev;
   rx_state_e         st;
   logic [TW-1:0]     tcnt;
   logic [NBW-1:0]    nbit;
   logic [DATA_W-1:0] sh;
   logic              push_q;
   logic [DATA_W-1:0] data_q;

   if (DATA_W < 2) begin : g_bad_width
      $error("con_rx: DATA_W must be at least 2");
   end

   assign rx_s    = sync[1];
   assign rx_prev = sync[2];
   assign push    = push_q;
   assign data    = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync   <= '1;
         st     <= RX_IDLE;
         tcnt   <= '0;
         nbit   <= '0;
         sh     <= '0;
         push_q <= 1'b0;
         data_q <= '0;
      end else begin
         sync   <= {sync[1:0], rxd};
         push_q <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (rx_prev && !rx_s) begin
                  st   <= RX_START;
                  tcnt <= '0;
               end
            end
            RX_START: if (tick) begin
               if (tcnt == TW'(HALF - 1)) begin
                  tcnt <= '0;
                  nbit <= '0;
                  st   <= rx_s ? RX_IDLE : RX_DATA;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_DATA: if (tick) begin
               if (tcnt == TW'(SAMP - 1)) begin
                  tcnt <= '0;
                  sh   <= {rx_s, sh[DATA_W-1:1]};
                  if (nbit == NBW'(DATA_W - 1)) st <= RX_STOP;
                  else                          nbit <= nbit + 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_STOP: if (tick) begin
               if (tcnt == TW'(SAMP - 1)) begin
                  tcnt <= '0;
                  st   <= RX_IDLE;
                  if (rx_s) begin
                     push_q <= 1'b1;
                     data_q <= sh;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   assert_stop_sampled_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $past(rx_s));

   assert_start_confirmed_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_DATA && $past(st) == RX_START) |-> !$past(rx_s));

endmodule

// File: rtl/con_uart.sv
module con_uart
   import con_uart_pkg::*;
#(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [63:0]       bus_wdata,
   output logic [63:0]       bus_rdata,
   output logic              txd,
   input  logic              rxd,
   output logic              irq
);
   localparam int unsigned IW = ADDR_W - 3;

   logic [IW-1:0]     idx;
   logic              hit;
   logic              sel_tx, sel_rx, sel_st, sel_dv, sel_ie;
   logic [DIV_W-1:0]  div_q, bcnt;
   logic              tick;
   logic [1:0]        ien_q;
   logic              tx_pop, tx_empty, tx_full;
   logic [CHAR_W-1:0] tx_head;
   logic              rx_push, rx_empty, rx_full;
   logic [CHAR_W-1:0] rx_byte, rx_head;
   logic              unused_bits;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("con_uart: ADDR_W must cover offset 0x20");
   end
   if (DIV_W < 1 || DIV_W > 64) begin : g_bad_div
      $error("con_uart: DIV_W out of range");
   end

   if (DIV_W < 64) begin : g_unused_hi
      assign unused_bits = ^bus_wdata[63:DIV_W];
   end else begin : g_unused_none
      assign unused_bits = 1'b0;
   end

   // register decode: 8-byte stride, aligned accesses only
   assign idx    = bus_addr[ADDR_W-1:3];
   assign hit    = (bus_addr[2:0] == 3'b000);
   assign sel_tx = hit && (idx == IW'(IDX_TXD));
   assign sel_rx = hit && (idx == IW'(IDX_RXD));
   assign sel_st = hit && (idx == IW'(IDX_STAT));
   assign sel_dv = hit && (idx == IW'(IDX_DIV));
   assign sel_ie = hit && (idx == IW'(IDX_IEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         ien_q <= '0;
      end else if (bus_wr) begin
         if (sel_dv) div_q <= bus_wdata[DIV_W-1:0];
         if (sel_ie) ien_q <= bus_wdata[1:0];
      end
   end

   // shared oversample tick: one pulse every div_q + 1 clocks
   assign tick = (bcnt >= div_q);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (tick) bcnt <= '0;
      else           bcnt <= bcnt + 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_rx)      bus_rdata[CHAR_W-1:0] = rx_empty ? '0 : rx_head;
      else if (sel_st) bus_rdata[3:0]        = {tx_full, rx_full, tx_empty, rx_empty};
      else if (sel_dv) bus_rdata[DIV_W-1:0]  = div_q;
      else if (sel_ie) bus_rdata[1:0]        = ien_q;
   end

   assign irq = (ien_q[0] && !rx_empty) || (ien_q[1] && tx_empty);

   con_fifo #(.DATA_W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (bus_wr && sel_tx),
      .din   (bus_wdata[CHAR_W-1:0]),
      .pop   (tx_pop),
      .dout  (tx_head),
      .empty (tx_empty),
      .full  (tx_full)
   );

   con_tx #(.DATA_W(CHAR_W), .SAMP(OSR)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .q_empty (tx_empty),
      .q_data  (tx_head),
      .q_pop   (tx_pop),
      .txd     (txd)
   );

   con_rx #(.DATA_W(CHAR_W), .SAMP(OSR)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .rxd   (rxd),
      .push  (rx_push),
      .data  (rx_byte)
   );

   con_fifo #(.DATA_W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .din   (rx_byte),
      .pop   (bus_rd && sel_rx),
      .dout  (rx_head),
      .empty (rx_empty),
      .full  (rx_full)
   );

endmodule

// File: tb/tb_con_uart.sv
`timescale 1ns/1ps
module tb_con_uart;
   localparam logic [5:0] A_TX = 6'h00, A_RX = 6'h08, A_ST = 6'h10, A_DV = 6'h18, A_IE = 6'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        txd;
   logic        rxd = 1'b1;
   logic        irq;

   int nvec = 0, nfail = 0, cyc = 0;
   int bit_cyc = 16;
   logic [7:0] exp_q[$];
   logic       done = 1'b0;

   con_uart dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd), .irq(irq)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all bus tasks start and end on a falling clock edge
   task automatic bus_write(input logic [5:0] a, input logic [63:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [63:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [5:0] a, output logic [63:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
   endtask

   // driver: queue the expected frame, then write the character
   task automatic send_tx(input logic [7:0] b, input bit expect_out);
      if (expect_out) exp_q.push_back(b);
      bus_write(A_TX, {56'h0, b});
   endtask

   task automatic send_rx(input logic [7:0] b, input bit stop);
      rxd = 1'b0;
      repeat (bit_cyc) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (bit_cyc) @(negedge clk);
      end
      rxd = stop;
      repeat (bit_cyc) @(negedge clk);
      rxd = 1'b1;
      repeat (bit_cyc) @(negedge clk);
   endtask

   task automatic wait_tx_drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2 * bit_cyc) @(negedge clk);
   endtask

   // monitor: decode frames from txd and compare against the scoreboard
   initial begin
      logic [7:0] got;
      logic       sb, pb;
      forever begin
         @(negedge txd);
         if (rst_n) begin
            repeat (bit_cyc / 2) @(negedge clk);
            sb = txd;
            for (int i = 0; i < 8; i++) begin
               repeat (bit_cyc) @(negedge clk);
               got[i] = txd;
            end
            repeat (bit_cyc) @(negedge clk);
            pb = txd;
            chk("R3 start bit low", {63'h0, sb}, 64'h0);
            chk("R3 stop bit high", {63'h0, pb}, 64'h1);
            if (exp_q.size() == 0) chk("R7 unexpected frame", {56'h0, got}, 64'hXX);
            else chk("R3 frame data/order", {56'h0, got}, {56'h0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      int t1, t2;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(A_ST, v); chk("R1 status after reset", v, 64'h3);
      peek(A_DV, v); chk("R1 divisor after reset", v, 64'h0);
      peek(A_IE, v); chk("R1 ien after reset", v, 64'h0);
      chk("R1 txd idle", {63'h0, txd}, 64'h1);
      chk("R1 irq low", {63'h0, irq}, 64'h0);

      // R9 transmit-empty interrupt, R3 basic frames
      bus_write(A_IE, 64'h2);
      chk("R9 irq on tx empty", {63'h0, irq}, 64'h1);
      send_tx(8'hA5, 1'b1);
      send_tx(8'h3C, 1'b1);
      send_tx(8'h01, 1'b1);
      peek(A_ST, v); chk("R2 tx-empty flag clear", v & 64'h2, 64'h0);
      chk("R9 irq drops with data queued", {63'h0, irq}, 64'h0);
      wait_tx_drain();
      chk("R9 irq back when tx empty", {63'h0, irq}, 64'h1);
      peek(A_ST, v); chk("R2 status idle", v, 64'h3);

      // R7 transmit overflow: first 17 land (16 queued + 1 taken by the idle shifter)
      for (int i = 0; i < 20; i++) send_tx(8'(8'h40 + i), i < 17);
      peek(A_ST, v); chk("R2 R7 tx-full flag", v, 64'h9);
      wait_tx_drain();
      repeat (200) @(negedge clk);
      chk("R7 no extra frames", exp_q.size(), 64'h0);
      bus_write(A_IE, 64'h0);

      // R4 divisor readback and bit period
      bus_write(A_DV, 64'h2);
      peek(A_DV, v); chk("R4 divisor readback", v, 64'h2);
      bit_cyc = 48;
      send_tx(8'h55, 1'b1);
      @(posedge txd); t1 = cyc;
      @(negedge txd); t2 = cyc;
      chk("R4 bit period 16*(div+1)", 64'(t2 - t1), 64'd48);
      wait_tx_drain();
      bus_write(A_DV, 64'h0);
      bit_cyc = 16;
      repeat (20) @(negedge clk);

      // R5 receive path, R9 receive interrupt
      bus_write(A_IE, 64'h1);
      chk("R9 irq low with rx empty", {63'h0, irq}, 64'h0);
      send_rx(8'h5A, 1'b1);
      peek(A_ST, v); chk("R2 rx-empty flag clear", v & 64'h1, 64'h0);
      chk("R9 irq on rx data", {63'h0, irq}, 64'h1);
      bus_read(A_RX, v); chk("R5 rx data", v, 64'h5A);
      peek(A_ST, v); chk("R5 pop empties queue", v & 64'h1, 64'h1);
      chk("R9 irq clears after pop", {63'h0, irq}, 64'h0);
      bus_write(A_IE, 64'h0);

      // R6 bad stop bit
      send_rx(8'h77, 1'b0);
      repeat (16) @(negedge clk);
      peek(A_ST, v); chk("R6 bad-stop frame dropped", v & 64'h1, 64'h1);

      // R10 short glitch
      rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
      repeat (40) @(negedge clk);
      peek(A_ST, v); chk("R10 glitch rejected", v & 64'h1, 64'h1);

      // R7 read of empty receive queue
      bus_read(A_RX, v); chk("R7 empty rx read", v, 64'h0);
      peek(A_ST, v); chk("R7 empty read no change", v, 64'h3);

      // R8 receive overflow
      for (int i = 0; i < 17; i++) send_rx(8'(8'hC0 + i), 1'b1);
      peek(A_ST, v); chk("R8 rx-full flag", v & 64'h5, 64'h4);
      for (int i = 0; i < 16; i++) begin
         bus_read(A_RX, v); chk("R8 rx order", v, 64'(8'hC0 + i));
      end
      peek(A_ST, v); chk("R8 17th dropped", v & 64'h1, 64'h1);

      // R11 read swept across the storing cycle
      for (int k = 0; k < 24; k++) begin
         send_rx(8'(8'h11 + k), 1'b1);
         fork
            send_rx(8'(8'h80 + k), 1'b1);
            begin
               repeat (9 * 16 + k) @(negedge clk);
               bus_read(A_RX, v);
               chk("R11 older char first", v, 64'(8'h11 + k));
            end
         join
         bus_read(A_RX, v); chk("R11 newer char kept", v, 64'(8'h80 + k));
         peek(A_ST, v); chk("R11 queue empty after", v & 64'h1, 64'h1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule